// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block decides which of several DMA request channels gets the system bus and manages the hold handshake with the host processor. Each channel has a request input and an acknowledge output. The block merges three things into one effective request per channel: the hardware request line, a software request bit, and a mask bit. When any channel has an effective request, the block asks the host for the bus. Once the host grants it, the block acknowledges the channel that has the highest priority. The block generates no addresses and counts no transfers. A transfer engine next to it tells the block when service is over, and whether that service ended on terminal count.

A channel can be marked as a cascade channel. In that case its request/acknowledge pair is wired to the hold-request/hold-acknowledge pair of a downstream controller. That controller then drives the bus while it holds the grant. This controller keeps its bus-ownership output low and waits for the downstream request to fall.

Three small registers are reached through a write port: mask, software request and cascade select. A status byte can be read at any time. There is no data stream, so all pins are plain control and status with no back-pressure.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, `hrq_o`, `dack_o` and `bus_own_o` are low, every channel is masked (mask = 4'b1111), the software request and cascade registers are zero, and the terminal-count flags in `status_o[3:0]` are zero.
- R2: While idle (`hrq_o` low), an effective request on any channel raises `hrq_o` on the next clock edge. A channel's effective request is (`dreq_i` | software bit) & ~mask.
- R3: `dack_o` is never set before `hlda_i` has been sampled high. It goes high on the edge that samples `hlda_i` high while `hrq_o` is high, and it is always one-hot or zero.
- R4: The grant goes to the lowest-numbered channel with an effective request at the edge where `hlda_i` is sampled. Channel 0 has the highest priority.
- R5: A write with `wr_sel_i` = 2'b00 loads the mask from `wr_data_i[3:0]` (bit n masks channel n). A masked channel neither raises `hrq_o` nor receives `dack_o`.
- R6: A write with `wr_sel_i` = 2'b01 loads the software request bits from `wr_data_i[3:0]`. A set bit behaves like a held `dreq_i`. The bit clears on the edge where that channel's service ends. If a write falls on the same cycle, the write wins.
- R7: A write with `wr_sel_i` = 2'b10 loads the cascade select bits. When a cascade channel is granted, `bus_own_o` stays low, `done_i` is ignored, and service ends when that channel's `dreq_i` falls. When a normal channel is granted, `bus_own_o` is high together with `dack_o`.
- R8: Service of a normal channel ends when `done_i` is sampled high. On that edge `dack_o`, `hrq_o` and `bus_own_o` all fall together. `dack_o` is never high while `hrq_o` is low.
- R9: `status_o[3:0]` holds per-channel terminal-count flags. A flag is set when service of that channel ends with `tc_i` high. All flags clear on the edge after `rd_en_i` is sampled high, but a flag being set on that same edge stays set. `status_o[7:4]` shows `dreq_i` | software bits, with no mask applied.
- R10: While a channel is in service, no new arbitration happens. `dack_o` keeps its value until the service ends, even if a higher-priority request arrives.
- R11: If every effective request disappears while the block is waiting for `hlda_i`, `hrq_o` falls on the next edge and no acknowledge is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dreq_i | input | 4 | Hardware request per channel (downstream hold request for cascade channels) |
| dack_o | output | 4 | Acknowledge per channel, one-hot |
| hrq_o | output | 1 | Hold request to the host |
| hlda_i | input | 1 | Hold acknowledge from the host |
| bus_own_o | output | 1 | High while this controller owns the bus for a normal channel |
| done_i | input | 1 | Transfer engine reports end of service of the granted normal channel |
| tc_i | input | 1 | Qualifies `done_i` as terminal count |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 00 mask, 01 software request, 10 cascade, 11 none |
| wr_data_i | input | 8 | Write data, bits [3:0] used |
| rd_en_i | input | 1 | Status read strobe, clears terminal-count flags |
| status_o | output | 8 | {raw pending requests, terminal-count flags} |

## Verification
Every registered result of this block arrives on the first clock edge after the input that causes it. That covers `hrq_o` after a request, `dack_o` and `bus_own_o` after `hlda_i`, the drop of all three after `done_i` or a falling cascade request, register loads after a write, and flag clearing after a read. The one exception is `status_o[7:4]`, which follows `dreq_i` without any register in between. The bench drives inputs just after a falling edge and samples at the next falling edge, so every check sees exactly one rising edge. Where a result needs two steps, such as a register write followed by the request it affects, the bench inserts one cycle on purpose and checks that the output has not yet changed.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    ARB_IDLE  = 2'b00,
    ARB_HOLD  = 2'b01,
    ARB_SERVE = 2'b10
  } arb_state_e;

  typedef enum logic [1:0] {
    SEL_MASK  = 2'b00,
    SEL_SWREQ = 2'b01,
    SEL_CASC  = 2'b10,
    SEL_NONE  = 2'b11
  } reg_sel_e;
endpackage

// File: rtl/dma_arb_regs.sv
module dma_arb_regs
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic             svc_end,
  input  logic             tc,
  input  logic [NCH-1:0]   grant,
  output logic [NCH-1:0]   mask_q,
  output logic [NCH-1:0]   swreq_q,
  output logic [NCH-1:0]   cas_q,
  output logic [NCH-1:0]   tcflag_q
);
  logic [NCH-1:0] swreq_d, tcflag_d;
  logic [NCH-1:0] wr_bits;

  assign wr_bits = wr_data[NCH-1:0];

  always_comb begin
    swreq_d = swreq_q;
    if (svc_end) swreq_d = swreq_q & ~grant;
    if (wr_en && reg_sel_e'(wr_sel) == SEL_SWREQ) swreq_d = wr_bits;
  end

  always_comb begin
    tcflag_d = rd_en ? '0 : tcflag_q;
    if (svc_end && tc) tcflag_d = tcflag_d | grant;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '1;
      swreq_q  <= '0;
      cas_q    <= '0;
      tcflag_q <= '0;
    end else begin
      swreq_q  <= swreq_d;
      tcflag_q <= tcflag_d;
      if (wr_en && reg_sel_e'(wr_sel) == SEL_MASK) mask_q <= wr_bits;
      if (wr_en && reg_sel_e'(wr_sel) == SEL_CASC) cas_q  <= wr_bits;
    end
  end
endmodule

// File: rtl/dma_arb_prio.sv
module dma_arb_prio #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] pick,
  output logic           any
);
  logic [NCH:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NCH; i++) begin : g_chain
    assign pick[i]   = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end

  assign any = seen[NCH];
endmodule

// File: rtl/dma_arb_fsm.sv
module dma_arb_fsm
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           any_req,
  input  logic [NCH-1:0] pick,
  input  logic [NCH-1:0] cas,
  input  logic [NCH-1:0] dreq,
  input  logic           hlda,
  input  logic           done,
  output logic           hrq,
  output logic [NCH-1:0] dack,
  output logic           bus_own,
  output logic           svc_end
);
  arb_state_e state_q;
  logic       cas_win;

  assign cas_win = |(dack & cas);
  assign svc_end = (state_q == ARB_SERVE) &&
                   (cas_win ? ~|(dreq & dack) : done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      hrq     <= 1'b0;
      dack    <= '0;
      bus_own <= 1'b0;
    end else begin
      unique case (state_q)
        ARB_IDLE: begin
          if (any_req) begin
            hrq     <= 1'b1;
            state_q <= ARB_HOLD;
          end
        end
        ARB_HOLD: begin
          if (!any_req) begin
            hrq     <= 1'b0;
            state_q <= ARB_IDLE;
          end else if (hlda) begin
            dack    <= pick;
            bus_own <= ~|(pick & cas);
            state_q <= ARB_SERVE;
          end
        end
        ARB_SERVE: begin
          if (svc_end) begin
            dack    <= '0;
            hrq     <= 1'b0;
            bus_own <= 1'b0;
            state_q <= ARB_IDLE;
          end
        end
        default: state_q <= ARB_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   dreq_i,
  output logic [NCH-1:0]   dack_o,
  output logic             hrq_o,
  input  logic             hlda_i,
  output logic             bus_own_o,
  input  logic             done_i,
  input  logic             tc_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [2*NCH-1:0] status_o
);
  logic [NCH-1:0] mask_q, swreq_q, cas_q, tcflag_q;
  logic [NCH-1:0] raw_req, eff_req, pick;
  logic           any_req, svc_end;

  assign raw_req  = dreq_i | swreq_q;
  assign eff_req  = raw_req & ~mask_q;
  assign status_o = {raw_req, tcflag_q};

  dma_arb_regs #(.NCH(NCH)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en_i),
    .wr_sel   (wr_sel_i),
    .wr_data  (wr_data_i),
    .rd_en    (rd_en_i),
    .svc_end  (svc_end),
    .tc       (tc_i),
    .grant    (dack_o),
    .mask_q   (mask_q),
    .swreq_q  (swreq_q),
    .cas_q    (cas_q),
    .tcflag_q (tcflag_q)
  );

  dma_arb_prio #(.NCH(NCH)) u_prio (
    .req  (eff_req),
    .pick (pick),
    .any  (any_req)
  );

  dma_arb_fsm #(.NCH(NCH)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .any_req (any_req),
    .pick    (pick),
    .cas     (cas_q),
    .dreq    (dreq_i),
    .hlda    (hlda_i),
    .done    (done_i),
    .hrq     (hrq_o),
    .dack    (dack_o),
    .bus_own (bus_own_o),
    .svc_end (svc_end)
  );
endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] dack_o,
  input logic           hrq_o,
  input logic           hlda_i,
  input logic           bus_own_o,
  input logic [NCH-1:0] eff_req,
  input logic [NCH-1:0] mask_q
);
  assert_dack_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack_o));

  assert_grant_after_hlda_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack_o && !$past(|dack_o)) |-> $past(hlda_i));

  assert_dack_needs_hrq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack_o) |-> hrq_o);

  assert_bus_own_with_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_own_o |-> (|dack_o));

  assert_grant_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack_o) |=> (dack_o == '0) || $stable(dack_o));

  assert_no_masked_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack_o && !$past(|dack_o)) |-> ((dack_o & $past(mask_q)) == '0));

  assert_hrq_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hrq_o && |eff_req) |=> hrq_o);
endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dack_o    (dack_o),
  .hrq_o     (hrq_o),
  .hlda_i    (hlda_i),
  .bus_own_o (bus_own_o),
  .eff_req   (eff_req),
  .mask_q    (mask_q)
);

// File: tb/dma_req_arbiter_bench.sv
module dma_req_arbiter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] dreq = '0;
  logic [3:0] dack;
  logic       hrq, hlda = 1'b0, bus_own;
  logic       done = 1'b0, tc = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'b11;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] status;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dma_req_arbiter u_dma_req_arbiter (
    .clk(clk), .rst_n(rst_n), .dreq_i(dreq), .dack_o(dack), .hrq_o(hrq),
    .hlda_i(hlda), .bus_own_o(bus_own), .done_i(done), .tc_i(tc),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .status_o(status)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic nstep();
    @(negedge clk);
  endtask

  task automatic write_reg(logic [1:0] sel, logic [3:0] val);
    wr_en = 1'b1; wr_sel = sel; wr_data = {4'h0, val};
    nstep();
    wr_en = 1'b0; wr_sel = 2'b11;
  endtask

  task automatic t_reset();
    check("R1 hrq", hrq, 0);
    check("R1 dack", dack, 0);
    check("R1 bus_own", bus_own, 0);
    check("R1 status", status, 0);
    dreq = 4'b0001;
    nstep(); nstep();
    check("R1 masked after reset", hrq, 0);
    dreq = '0;
    write_reg(2'b00, 4'b0000);
  endtask

  task automatic t_normal();
    dreq = 4'b0001;
    nstep();
    check("R2 hrq rises", hrq, 1);
    check("R3 no dack before hlda", dack, 0);
    nstep();
    check("R3 still no dack", dack, 0);
    hlda = 1'b1;
    nstep();
    check("R3 dack after hlda", dack, 4'b0001);
    check("R7 bus_own normal", bus_own, 1);
    done = 1'b1; tc = 1'b1;
    nstep();
    done = 1'b0; tc = 1'b0; hlda = 1'b0; dreq = '0;
    check("R8 dack drops", dack, 0);
    check("R8 hrq drops", hrq, 0);
    check("R8 bus_own drops", bus_own, 0);
    check("R9 tc flag set", status[3:0], 4'b0001);
    rd_en = 1'b1;
    nstep();
    rd_en = 1'b0;
    check("R9 flag cleared on read", status[3:0], 0);
  endtask

  task automatic t_priority();
    dreq = 4'b1100;
    nstep();
    check("R2 hrq", hrq, 1);
    dreq = 4'b1110; hlda = 1'b1;
    nstep();
    check("R4 winner at hlda edge", dack, 4'b0010);
    dreq = 4'b1111;
    nstep();
    check("R10 no re-arbitration", dack, 4'b0010);
    check("R9 pending bits", status[7:4], 4'b1111);
    done = 1'b1;
    nstep();
    done = 1'b0; hlda = 1'b0;
    check("R8 end", dack, 0);
    nstep();
    check("R2 re-request", hrq, 1);
    hlda = 1'b1;
    nstep();
    check("R4 channel 0 highest", dack, 4'b0001);
    done = 1'b1; dreq = '0;
    nstep();
    done = 1'b0; hlda = 1'b0;
    nstep();
  endtask

  task automatic t_mask();
    write_reg(2'b00, 4'b0001);
    dreq = 4'b0001;
    nstep(); nstep();
    check("R5 masked no hrq", hrq, 0);
    check("R9 raw pending shown", status[7:4], 4'b0001);
    dreq = 4'b0011;
    nstep();
    check("R5 unmasked hrq", hrq, 1);
    hlda = 1'b1;
    nstep();
    check("R5 masked not granted", dack, 4'b0010);
    done = 1'b1; dreq = '0;
    nstep();
    done = 1'b0; hlda = 1'b0;
    write_reg(2'b00, 4'b0000);
  endtask

  task automatic t_swreq();
    write_reg(2'b01, 4'b0100);
    check("R6 no hrq yet", hrq, 0);
    check("R6 soft request pending", status[7:4], 4'b0100);
    nstep();
    check("R6 hrq from soft request", hrq, 1);
    hlda = 1'b1;
    nstep();
    check("R6 soft request granted", dack, 4'b0100);
    done = 1'b1;
    nstep();
    done = 1'b0; hlda = 1'b0;
    check("R6 soft bit cleared", status[7:4], 0);
    check("R9 no tc flag without tc", status[3:0], 0);
    nstep();
    check("R6 no re-request", hrq, 0);
  endtask

  task automatic t_cascade();
    write_reg(2'b10, 4'b0010);
    dreq = 4'b0010;
    nstep();
    check("R7 hrq", hrq, 1);
    hlda = 1'b1;
    nstep();
    check("R7 cascade granted", dack, 4'b0010);
    check("R7 bus_own low", bus_own, 0);
    done = 1'b1;
    nstep();
    done = 1'b0;
    check("R7 done ignored", dack, 4'b0010);
    dreq = '0;
    nstep();
    hlda = 1'b0;
    check("R7 ends on dreq fall", dack, 0);
    check("R7 hrq drops", hrq, 0);
    write_reg(2'b10, 4'b0000);
  endtask

  task automatic t_withdraw();
    dreq = 4'b1000;
    nstep();
    check("R11 hrq", hrq, 1);
    dreq = '0;
    nstep();
    check("R11 hrq withdrawn", hrq, 0);
    hlda = 1'b1;
    nstep();
    check("R11 no dack", dack, 0);
    hlda = 1'b0;
  endtask

  task automatic t_read_race();
    dreq = 4'b1000;
    nstep();
    hlda = 1'b1;
    nstep();
    check("R3 dack ch3", dack, 4'b1000);
    done = 1'b1; tc = 1'b1; rd_en = 1'b1;
    nstep();
    done = 1'b0; tc = 1'b0; rd_en = 1'b0; hlda = 1'b0; dreq = '0;
    check("R9 set wins over clear", status[3:0], 4'b1000);
    rd_en = 1'b1;
    nstep();
    rd_en = 1'b0;
    check("R9 cleared", status[3:0], 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    nstep(); nstep();
    rst_n = 1'b1;
    nstep();
    t_reset();
    t_normal();
    t_priority();
    t_mask();
    t_swreq();
    t_cascade();
    t_withdraw();
    t_read_race();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule